// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

This block links a host bus to an embedded controller CPU through two one-byte mailboxes and one shared status byte. The host writes a byte into the inbound mailbox. Its address select line marks that byte as a command or as data. The host reads the outbound mailbox or the status byte. The CPU fetches the inbound byte, posts an outbound byte and maintains a few general-purpose status bits.

Hardware owns the handshake. A host write fills the inbound mailbox and raises the CPU's inbound interrupt. A CPU fetch empties it. A CPU post fills the outbound mailbox and raises the host interrupt. A host read of the outbound byte empties it. Each interrupt is gated by its own enable input.

Everything runs on one clock. All strobes are single-cycle pulses that are already synchronous to that clock. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `host_ctrl_mailbox`

## Requirements
- R1: After reset, the status byte is 00h, both mailbox bytes are 00h and both interrupt outputs are low.
- R2: A host write (host_cs=1, host_wr=1) loads host_wdata into the inbound byte seen on cpu_in_data, and sets the inbound-full flag (status bit 1) from the next cycle.
- R3: On every host write, the command tag (status bit 3) takes the value of host_a: 1 marks a command and 0 marks data.
- R4: A CPU fetch pulse (cpu_rd_in=1) clears the inbound-full flag from the next cycle, unless a host write occurs in the same cycle.
- R5: A CPU post pulse (cpu_wr_out=1) loads cpu_wdata into the outbound byte and sets the outbound-full flag (status bit 0) from the next cycle.
- R6: While host_cs=1 and host_rd=1, host_rdata shows the outbound byte when host_a=0 and the status byte when host_a=1; otherwise it is 00h. Only a host read with host_a=0 clears the outbound-full flag, unless a CPU post occurs in the same cycle.
- R7: A CPU status write (cpu_wr_stat=1) loads bits 7:4 and bit 2 from cpu_wdata and leaves bits 3, 1 and 0 unchanged.
- R8: When a flag is set and cleared in the same cycle, the set wins, for both the inbound-full and the outbound-full flag.
- R9: host_irq is high exactly when the outbound-full flag is 1 and host_irq_en is 1, so it falls on the host read that empties the mailbox.
- R10: cpu_ibf_irq is high exactly when the inbound-full flag is 1 and cpu_irq_en is 1.
- R11: host_rd or host_wr pulses with host_cs=0 change no state.
- R12: The host has no access path to the general-purpose status bits; host writes leave bits 7:4 and 2 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_a | input | 1 | Host address select: 0 = data, 1 = command/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_irq | output | 1 | Outbound byte ready interrupt |
| host_irq_en | input | 1 | Enable for host_irq |
| cpu_rd_in | input | 1 | CPU fetch of inbound byte, one cycle |
| cpu_wr_out | input | 1 | CPU post of outbound byte, one cycle |
| cpu_wr_stat | input | 1 | CPU write of general-purpose status bits |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_in_data | output | 8 | Inbound byte |
| cpu_status | output | 8 | Status byte |
| cpu_ibf_irq | output | 1 | Inbound-full interrupt |
| cpu_irq_en | input | 1 | Enable for cpu_ibf_irq |

## Verification
The hardest cases to reach are the collisions. In these, one side's set and the other side's clear of the same flag fall in one cycle. Normal host-then-CPU traffic never produces them. The bench raises the two strobes on the same falling edge for both flags, and then checks that the flag stayed set and the interrupt stayed high. Every byte value is swept through both mailboxes and through the status write path with the hardware bits held at 1, so a leak into the wrong bit field shows up for some value.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int STAT_W  = 8;
  localparam int OBF_BIT = 0;
  localparam int IBF_BIT = 1;
  localparam int CD_BIT  = 3;
  localparam logic [STAT_W-1:0] GP_MASK = 8'hF4;

  typedef struct packed {
    logic host_wr;
    logic host_rd_data;
    logic cpu_rd_in;
    logic cpu_wr_out;
    logic cpu_wr_stat;
  } mbx_ev_t;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/mbx_byte_reg.sv
module mbx_byte_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  // R2 / R5: the byte is captured on a load and held otherwise
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mbx_ev_t           ev,
  input  logic              host_a,
  input  logic [STAT_W-1:0] cpu_wdata,
  output logic [STAT_W-1:0] status
);
  logic ibf_q, ibf_d;
  logic obf_q, obf_d;
  logic cd_q, cd_d;
  logic [STAT_W-1:0] gp_q, gp_d;

  always_comb begin
    ibf_d = ibf_q;
    if (ev.cpu_rd_in) ibf_d = 1'b0;
    if (ev.host_wr)   ibf_d = 1'b1;

    obf_d = obf_q;
    if (ev.host_rd_data) obf_d = 1'b0;
    if (ev.cpu_wr_out)   obf_d = 1'b1;

    cd_d = cd_q;
    if (ev.host_wr) cd_d = host_a;

    gp_d = gp_q;
    if (ev.cpu_wr_stat) gp_d = cpu_wdata & GP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
      cd_q  <= 1'b0;
      gp_q  <= '0;
    end else begin
      ibf_q <= ibf_d;
      obf_q <= obf_d;
      cd_q  <= cd_d;
      gp_q  <= gp_d;
    end
  end

  always_comb begin
    status          = gp_q;
    status[OBF_BIT] = obf_q;
    status[IBF_BIT] = ibf_q;
    status[CD_BIT]  = cd_q;
  end

  p_ibf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev.host_wr |=> status[IBF_BIT]);
  p_cd_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev.host_wr |=> (status[CD_BIT] == $past(host_a)));
  p_ibf_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.cpu_rd_in && !ev.host_wr) |=> !status[IBF_BIT]);
  p_obf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev.cpu_wr_out |=> status[OBF_BIT]);
  p_obf_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.host_rd_data && !ev.cpu_wr_out) |=> !status[OBF_BIT]);
  p_gp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev.cpu_wr_stat |=> $stable(status & GP_MASK));
  p_gp_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.cpu_wr_stat && !ev.host_wr) |=> (status[CD_BIT] == $past(status[CD_BIT])));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.host_wr && ev.cpu_rd_in) |=> status[IBF_BIT]);
endmodule

// File: rtl/host_ctrl_mailbox.sv
module host_ctrl_mailbox
  import mbx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_cs,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic          host_a,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_irq,
  input  logic          host_irq_en,
  input  logic          cpu_rd_in,
  input  logic          cpu_wr_out,
  input  logic          cpu_wr_stat,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_in_data,
  output logic [DW-1:0] cpu_status,
  output logic          cpu_ibf_irq,
  input  logic          cpu_irq_en
);
  logic    rst_n_s;
  mbx_ev_t ev;
  logic    host_rd_sel;
  logic [DW-1:0] out_q;
  logic [STAT_W-1:0] status;

  mbx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  always_comb begin
    host_rd_sel     = host_cs & host_rd;
    ev.host_wr      = host_cs & host_wr;
    ev.host_rd_data = host_rd_sel & ~host_a;
    ev.cpu_rd_in    = cpu_rd_in;
    ev.cpu_wr_out   = cpu_wr_out;
    ev.cpu_wr_stat  = cpu_wr_stat;
  end

  mbx_byte_reg #(.W(DW)) u_in_byte (
    .clk(clk), .rst_n(rst_n_s), .load(ev.host_wr), .d(host_wdata), .q(cpu_in_data)
  );

  mbx_byte_reg #(.W(DW)) u_out_byte (
    .clk(clk), .rst_n(rst_n_s), .load(ev.cpu_wr_out), .d(cpu_wdata), .q(out_q)
  );

  mbx_flags u_flags (
    .clk(clk), .rst_n(rst_n_s), .ev(ev), .host_a(host_a),
    .cpu_wdata(cpu_wdata[STAT_W-1:0]), .status(status)
  );

  assign cpu_status = status;

  always_comb begin
    host_rdata = '0;
    if (host_rd_sel) host_rdata = host_a ? status : out_q;
  end

  assign host_irq    = status[OBF_BIT] & host_irq_en;
  assign cpu_ibf_irq = status[IBF_BIT] & cpu_irq_en;

  p_hirq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ev.host_rd_data && !cpu_wr_out) |=> !host_irq);
  p_cirq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_rd_in && !ev.host_wr) |=> !cpu_ibf_irq);
  p_nocs_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!host_cs && !cpu_rd_in && !cpu_wr_out && !cpu_wr_stat) |=> $stable(cpu_status));
  p_host_gp_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cpu_wr_stat |=> ((cpu_status & GP_MASK) == $past(cpu_status & GP_MASK)));
endmodule

// File: tb/host_ctrl_mailbox_test.sv
module host_ctrl_mailbox_test;
  logic clk = 1'b0;
  logic rst_n;
  logic host_cs, host_rd, host_wr, host_a;
  logic [7:0] host_wdata, host_rdata;
  logic host_irq, host_irq_en;
  logic cpu_rd_in, cpu_wr_out, cpu_wr_stat;
  logic [7:0] cpu_wdata, cpu_in_data, cpu_status;
  logic cpu_ibf_irq, cpu_irq_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  host_ctrl_mailbox #(.DW(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr), .host_a(host_a),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .host_irq_en(host_irq_en),
    .cpu_rd_in(cpu_rd_in), .cpu_wr_out(cpu_wr_out), .cpu_wr_stat(cpu_wr_stat),
    .cpu_wdata(cpu_wdata), .cpu_in_data(cpu_in_data), .cpu_status(cpu_status),
    .cpu_ibf_irq(cpu_ibf_irq), .cpu_irq_en(cpu_irq_en)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_cs = 1; host_wr = 1; host_a = a; host_wdata = d;
    @(negedge clk);
    host_cs = 0; host_wr = 0;
  endtask

  task automatic host_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    host_cs = 1; host_rd = 1; host_a = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_cs = 0; host_rd = 0;
  endtask

  task automatic cpu_fetch(output logic [7:0] d);
    @(negedge clk);
    cpu_rd_in = 1;
    #1 d = cpu_in_data;
    @(negedge clk);
    cpu_rd_in = 0;
  endtask

  task automatic cpu_post(input logic [7:0] d);
    @(negedge clk);
    cpu_wr_out = 1; cpu_wdata = d;
    @(negedge clk);
    cpu_wr_out = 0;
  endtask

  task automatic cpu_stat(input logic [7:0] d);
    @(negedge clk);
    cpu_wr_stat = 1; cpu_wdata = d;
    @(negedge clk);
    cpu_wr_stat = 0;
  endtask

  function automatic logic [7:0] stat_exp(input logic [7:0] gp, input logic cd,
                                          input logic ibf, input logic obf);
    return (gp & 8'hF4) | {4'b0, cd, 1'b0, ibf, obf};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] gp;
    logic cd;
    rst_n = 0;
    host_cs = 0; host_rd = 0; host_wr = 0; host_a = 0; host_wdata = 0;
    host_irq_en = 0; cpu_irq_en = 0;
    cpu_rd_in = 0; cpu_wr_out = 0; cpu_wr_stat = 0; cpu_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 status", cpu_status, 8'h00);
    check("R1 in byte", cpu_in_data, 8'h00);
    check("R1 irqs", {6'b0, host_irq, cpu_ibf_irq}, 8'h00);
    host_read(1'b0, rd);
    check("R1 out byte", rd, 8'h00);

    gp = 8'h00;
    cd = 1'b0;
    // Sweep all byte values through both mailboxes
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = v[7:0];
      host_irq_en = b[1];
      cpu_irq_en  = b[2];
      host_write(b[0], b);
      cd = b[0];
      check("R2 in byte", cpu_in_data, b);
      check("R3 cd/ibf", cpu_status, stat_exp(gp, cd, 1'b1, 1'b0));
      check("R10 cpu irq", {7'b0, cpu_ibf_irq}, {7'b0, b[2]});
      cpu_fetch(rd);
      check("R2 fetch", rd, b);
      check("R4 ibf clear", cpu_status, stat_exp(gp, cd, 1'b0, 1'b0));
      check("R10 cpu irq off", {7'b0, cpu_ibf_irq}, 8'h00);
      cpu_post(~b);
      check("R5 obf", cpu_status, stat_exp(gp, cd, 1'b0, 1'b1));
      check("R9 host irq", {7'b0, host_irq}, {7'b0, b[1]});
      host_read(1'b1, rd);
      check("R6 status read keeps obf", rd, stat_exp(gp, cd, 1'b0, 1'b1));
      host_read(1'b0, rd);
      check("R6 out byte", rd, ~b);
      check("R6 obf clear", cpu_status, stat_exp(gp, cd, 1'b0, 1'b0));
      check("R9 host irq off", {7'b0, host_irq}, 8'h00);
    end

    // Hardware bits high, then sweep status writes
    host_irq_en = 1; cpu_irq_en = 1;
    host_write(1'b1, 8'h5A);
    cpu_post(8'hC3);
    cd = 1'b1;
    for (int v = 0; v < 256; v++) begin
      cpu_stat(v[7:0]);
      gp = v[7:0] & 8'hF4;
      check("R7 status write", cpu_status, stat_exp(gp, 1'b1, 1'b1, 1'b1));
    end
    cpu_stat(8'h0B);
    check("R7 hw bits kept", cpu_status, stat_exp(8'h00, 1'b1, 1'b1, 1'b1));
    cpu_stat(8'hA4);
    gp = 8'hA4;

    // R12: host writes leave general-purpose bits alone
    host_write(1'b0, 8'hFF);
    check("R12 gp after host write", cpu_status, stat_exp(gp, 1'b0, 1'b1, 1'b1));
    host_write(1'b1, 8'h00);
    check("R12 gp after host cmd", cpu_status, stat_exp(gp, 1'b1, 1'b1, 1'b1));

    // R11: strobes without chip select
    @(negedge clk);
    host_wr = 1; host_a = 0; host_wdata = 8'h77;
    @(negedge clk);
    host_wr = 0;
    check("R11 wr no cs status", cpu_status, stat_exp(gp, 1'b1, 1'b1, 1'b1));
    check("R11 wr no cs byte", cpu_in_data, 8'h00);
    @(negedge clk);
    host_rd = 1; host_a = 0;
    #1 check("R6 rdata idle", host_rdata, 8'h00);
    @(negedge clk);
    host_rd = 0;
    check("R11 rd no cs obf", cpu_status, stat_exp(gp, 1'b1, 1'b1, 1'b1));

    // R8: collisions, both flags
    @(negedge clk);
    host_cs = 1; host_wr = 1; host_a = 0; host_wdata = 8'h3C; cpu_rd_in = 1;
    @(negedge clk);
    host_cs = 0; host_wr = 0; cpu_rd_in = 0;
    check("R8 ibf set wins", cpu_status, stat_exp(gp, 1'b0, 1'b1, 1'b1));
    check("R8 new byte kept", cpu_in_data, 8'h3C);
    check("R8 cpu irq held", {7'b0, cpu_ibf_irq}, 8'h01);
    @(negedge clk);
    host_cs = 1; host_rd = 1; host_a = 0; cpu_wr_out = 1; cpu_wdata = 8'h99;
    #1 check("R8 read sees old byte", host_rdata, 8'hC3);
    @(negedge clk);
    host_cs = 0; host_rd = 0; cpu_wr_out = 0;
    check("R8 obf set wins", cpu_status, stat_exp(gp, 1'b0, 1'b1, 1'b1));
    check("R9 host irq held", {7'b0, host_irq}, 8'h01);
    host_irq_en = 0; cpu_irq_en = 0;
    #1 check("R9/R10 enables gate", {6'b0, host_irq, cpu_ibf_irq}, 8'h00);
    host_read(1'b0, rd);
    check("R8 new out byte", rd, 8'h99);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule